// File: doc/BRIEF.md
# Vectored Four-Source Interrupt Controller

This block is the interrupt front end of a small 4-bit processor. It serves four sources: one external pin and three timer underflow strobes. Each source has a request flag. The flag latches on its event whether or not the source is unmasked, and it holds until the sequencer services that source or a skip test consumes it.

A global enable flag, driven by enable and disable commands from the instruction decoder, gates the request toward the sequencer. The controller picks the highest-priority pending and unmasked source and presents its vector address in the interrupt page. When the sequencer acknowledges, the controller clears the global enable and the serviced flag only.

A masked source can be polled instead. A skip test on that source returns its flag and consumes it. The external pin passes through a synchronizer and a stability filter, and one configuration bit chooses which edge counts.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `irqReq` is 1 exactly when the global enable is 1 and at least one source has both its request flag and its enable bit at 1. `irqReq` is 0 while the global enable is 0.
- R2: A timer underflow pulse or a qualified external edge sets that source's flag whatever its enable bit and the global enable are. The flag stays set until it is serviced or consumed by a skip test.
- R3: An acknowledge (`irqAck`=1 while `irqReq`=1) clears the global enable and clears only the flag of the source reported on `irqSrc`. Other pending flags remain.
- R4: Priority order is external (source 0), then timer 1 (source 1), timer 2 (source 2) and timer 3 (source 3). The vector is page base 128 plus an offset: 0x80 for source 0, 0x84 for source 1, 0x86 for source 2 and 0x88 for source 3. `irqSrc` carries the source index.
- R5: After `eiCmd`, the global enable becomes 1 only at the clock edge where the next `instrDone` pulse is sampled. `diCmd` clears the global enable and cancels a pending enable at the next edge.
- R6: The write selector `regSel` takes these values: 0 writes control A, 1 writes control B, 2 writes the edge configuration, and 3 writes nothing. Source 0 is enabled by A bit 0, source 1 by A bit 2, source 2 by A bit 3, and source 3 by B bit 0. The remaining bits can be written and read back with no effect. All three registers are 0 after reset.
- R7: Bit 2 of the edge configuration selects the active edge of `extPin`: 0 means falling and 1 means rising. A new pin level held for fewer than 4 cycles is ignored. The opposite edge never sets the flag.
- R8: A skip test (`skipReq` with `skipSrc`) on a source whose enable bit is 0 sets `skipHit` on the next cycle to that source's flag and clears the flag. If the source's enable bit is 1, `skipHit` is 0 on the next cycle and the flag is kept.
- R9: After reset the global enable, all flags, `irqReq`, `skipHit` and all registers are 0.
- R10: When a flag's event and a clear of the same flag happen in one cycle, the flag ends up set. A skip test in that cycle reports the old flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrUnderflow | input | 3 | One-cycle underflow strobes of timers 1..3 |
| extPin | input | 1 | Asynchronous external interrupt pin |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 ctrl A, 1 ctrl B, 2 edge config) |
| regWrData | input | 4 | Register write data |
| eiCmd | input | 1 | Enable-interrupts command |
| diCmd | input | 1 | Disable-interrupts command |
| instrDone | input | 1 | Instruction completion pulse |
| skipReq | input | 1 | Skip-test request |
| skipSrc | input | 2 | Source tested by the skip request |
| irqAck | input | 1 | Interrupt acknowledge from the sequencer |
| irqReq | output | 1 | Interrupt request toward the sequencer |
| irqSrc | output | 2 | Index of the selected source |
| vecAddr | output | ADDR_W | Vector address of the selected source |
| skipHit | output | 1 | Skip-test result, valid one cycle after the request |
| ctrlA | output | 4 | Control register A read value |
| ctrlB | output | 4 | Control register B read value |
| edgeCfg | output | 4 | Edge configuration read value |

## Verification
The bench uses the default parameters: a 14-bit vector address, page 1 of 128 words, a 4-cycle filter and a 2-stage synchronizer. At these values each vector offset can be checked as an exact address. The 4-cycle filter is short enough that a 2-cycle glitch and a 10-cycle hold fall on either side of it within a few clocks. Random enable patterns and timer bursts run the priority encoder over many pending sets. Skip tests then read back every remaining flag through the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int REG_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL_A = 2'd0,
    SEL_CTRL_B = 2'd1,
    SEL_EDGE   = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrFlag;
    logic               skipLatch;
    logic [SRC_W-1:0]   skipSel;
  } irqStrobe_t;
endpackage

// File: rtl/irq_edge_filter.sv
module irq_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic riseSel,
  output logic edgeHit
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   stableQ;
  logic [CW-1:0]          cntQ;
  logic                   hitQ;
  logic                   synced;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= 1'b1;
          else       syncQ[s] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= 1'b1;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign synced = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stableQ <= 1'b1;
      cntQ    <= '0;
      hitQ    <= 1'b0;
    end else begin
      hitQ <= 1'b0;
      if (synced != stableQ) begin
        if (cntQ == CW'(FILT_CYCLES - 1)) begin
          stableQ <= synced;
          cntQ    <= '0;
          hitQ    <= (synced == riseSel);
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end else begin
        cntQ <= '0;
      end
    end
  end

  assign edgeHit = hitQ;
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int VEC_PAGE    = 1,
  parameter int PAGE_WORDS  = 128,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-2:0] tmrUnderflow,
  input  logic               extPin,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [REG_W-1:0]   regWrData,
  input  irqStrobe_t         strobe,
  output logic [NUM_SRC-1:0] enMask,
  output logic [NUM_SRC-1:0] pendMask,
  output logic [SRC_W-1:0]   topSrc,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               skipHit,
  output logic [REG_W-1:0]   ctrlA,
  output logic [REG_W-1:0]   ctrlB,
  output logic [REG_W-1:0]   edgeCfg
);
  localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(VEC_PAGE * PAGE_WORDS);

  logic [REG_W-1:0]   ctrlAQ, ctrlBQ, edgeQ;
  logic [NUM_SRC-1:0] flagQ, setVec;
  logic               skipHitQ;
  logic               extHit;

  function automatic logic [ADDR_W-1:0] vecOffset(input logic [SRC_W-1:0] src);
    if (src == '0) return '0;
    return ADDR_W'(2 + 2 * int'(src));
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlAQ <= '0;
      ctrlBQ <= '0;
      edgeQ  <= '0;
    end else if (regWrEn) begin
      case (regSel_e'(regSel))
        SEL_CTRL_A: ctrlAQ <= regWrData;
        SEL_CTRL_B: ctrlBQ <= regWrData;
        SEL_EDGE:   edgeQ  <= regWrData;
        default:    ;
      endcase
    end
  end

  irq_edge_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) u_edge (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (extPin),
    .riseSel(edgeQ[2]),
    .edgeHit(extHit)
  );

  assign setVec = {tmrUnderflow, extHit};

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rstN)          flagQ[i] <= 1'b0;
        else if (setVec[i]) flagQ[i] <= 1'b1;
        else if (strobe.clrFlag[i]) flagQ[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) skipHitQ <= 1'b0;
    else       skipHitQ <= strobe.skipLatch && flagQ[strobe.skipSel];
  end

  assign enMask   = {ctrlBQ[0], ctrlAQ[3], ctrlAQ[2], ctrlAQ[0]};
  assign pendMask = flagQ & enMask;

  always_comb begin
    topSrc = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendMask[i]) topSrc = SRC_W'(i);
    end
  end

  assign vecAddr = VEC_BASE + vecOffset(topSrc);
  assign skipHit = skipHitQ;
  assign ctrlA   = ctrlAQ;
  assign ctrlB   = ctrlBQ;
  assign edgeCfg = edgeQ;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               eiCmd,
  input  logic               diCmd,
  input  logic               instrDone,
  input  logic               irqAck,
  input  logic               skipReq,
  input  logic [SRC_W-1:0]   skipSrc,
  input  logic [NUM_SRC-1:0] enMask,
  input  logic [NUM_SRC-1:0] pendMask,
  input  logic [SRC_W-1:0]   topSrc,
  output logic               gie,
  output logic               irqReq,
  output irqStrobe_t         strobe
);
  logic gieQ, eiArmQ;
  logic irqTake, skipOk;

  assign irqReq  = gieQ && (|pendMask);
  assign irqTake = irqAck && irqReq;
  assign skipOk  = skipReq && !enMask[skipSrc];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieQ   <= 1'b0;
      eiArmQ <= 1'b0;
    end else if (diCmd || irqTake) begin
      gieQ   <= 1'b0;
      eiArmQ <= 1'b0;
    end else if (eiCmd) begin
      eiArmQ <= 1'b1;
    end else if (eiArmQ && instrDone) begin
      gieQ   <= 1'b1;
      eiArmQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.clrFlag = '0;
    if (irqTake) strobe.clrFlag[topSrc] = 1'b1;
    if (skipOk)  strobe.clrFlag[skipSrc] = 1'b1;
    strobe.skipLatch = skipOk;
    strobe.skipSel   = skipSrc;
  end

  assign gie = gieQ;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int ADDR_W      = 14,
  parameter int VEC_PAGE    = 1,
  parameter int PAGE_WORDS  = 128,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        tmrUnderflow,
  input  logic              extPin,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [3:0]        regWrData,
  input  logic              eiCmd,
  input  logic              diCmd,
  input  logic              instrDone,
  input  logic              skipReq,
  input  logic [1:0]        skipSrc,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [1:0]        irqSrc,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              skipHit,
  output logic [3:0]        ctrlA,
  output logic [3:0]        ctrlB,
  output logic [3:0]        edgeCfg
);
  import irq_pkg::*;

  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] enMask, pendMask;
  logic [SRC_W-1:0]   topSrc;
  logic               gie;

  irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .eiCmd    (eiCmd),
    .diCmd    (diCmd),
    .instrDone(instrDone),
    .irqAck   (irqAck),
    .skipReq  (skipReq),
    .skipSrc  (skipSrc),
    .enMask   (enMask),
    .pendMask (pendMask),
    .topSrc   (topSrc),
    .gie      (gie),
    .irqReq   (irqReq),
    .strobe   (strobe)
  );

  irq_datapath #(
    .ADDR_W     (ADDR_W),
    .VEC_PAGE   (VEC_PAGE),
    .PAGE_WORDS (PAGE_WORDS),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tmrUnderflow(tmrUnderflow),
    .extPin      (extPin),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .regWrData   (regWrData),
    .strobe      (strobe),
    .enMask      (enMask),
    .pendMask    (pendMask),
    .topSrc      (topSrc),
    .vecAddr     (vecAddr),
    .skipHit     (skipHit),
    .ctrlA       (ctrlA),
    .ctrlB       (ctrlB),
    .edgeCfg     (edgeCfg)
  );

  assign irqSrc = topSrc;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int ADDR_W     = 14,
  parameter int VEC_PAGE   = 1,
  parameter int PAGE_WORDS = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic              irqAck,
  input logic [ADDR_W-1:0] vecAddr,
  input logic [1:0]        irqSrc,
  input logic              skipReq,
  input logic [1:0]        skipSrc,
  input logic              skipHit,
  input logic [3:0]        ctrlA,
  input logic [3:0]        ctrlB,
  input logic              instrDone,
  input logic              gie
);
  localparam int BASE = VEC_PAGE * PAGE_WORDS;

  logic srcEn;
  always_comb begin
    case (skipSrc)
      2'd0:    srcEn = ctrlA[0];
      2'd1:    srcEn = ctrlA[2];
      2'd2:    srcEn = ctrlA[3];
      default: srcEn = ctrlB[0];
    endcase
  end

  // R3
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> !irqReq);

  // R4
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((irqSrc == 2'd0 && vecAddr == ADDR_W'(BASE))     ||
                (irqSrc == 2'd1 && vecAddr == ADDR_W'(BASE + 4)) ||
                (irqSrc == 2'd2 && vecAddr == ADDR_W'(BASE + 6)) ||
                (irqSrc == 2'd3 && vecAddr == ADDR_W'(BASE + 8))));

  // R8
  skip_hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    skipHit |-> $past(skipReq));

  // R8
  skip_masked_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipReq && srcEn) |=> !skipHit);

  // R5
  enable_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gie) |-> $past(instrDone));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .VEC_PAGE  (VEC_PAGE),
  .PAGE_WORDS(PAGE_WORDS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqReq   (irqReq),
  .irqAck   (irqAck),
  .vecAddr  (vecAddr),
  .irqSrc   (irqSrc),
  .skipReq  (skipReq),
  .skipSrc  (skipSrc),
  .skipHit  (skipHit),
  .ctrlA    (ctrlA),
  .ctrlB    (ctrlB),
  .instrDone(instrDone),
  .gie      (gie)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  tmrUnderflow = '0;
  logic        extPin = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [3:0]  regWrData = '0;
  logic        eiCmd = 1'b0, diCmd = 1'b0, instrDone = 1'b0;
  logic        skipReq = 1'b0;
  logic [1:0]  skipSrc = '0;
  logic        irqAck = 1'b0;
  logic        irqReq, skipHit;
  logic [1:0]  irqSrc;
  logic [13:0] vecAddr;
  logic [3:0]  ctrlA, ctrlB, edgeCfg;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  irq_vector_ctrl uut (.*);

  always #4 clk = ~clk;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expVec(input logic [3:0] p);
    for (int i = 0; i < 4; i++)
      if (p[i]) return 128 + ((i == 0) ? 0 : 2 + 2 * i);
    return 128;
  endfunction

  function automatic int expSrc(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic wrReg(input logic [1:0] sel, input logic [3:0] d);
    regWrEn = 1; regSel = sel; regWrData = d; step(); regWrEn = 0;
  endtask

  task automatic pulseTmr(input logic [2:0] m);
    tmrUnderflow = m; step(); tmrUnderflow = '0;
  endtask

  task automatic doEi();
    eiCmd = 1; step(); eiCmd = 0;
  endtask

  task automatic doDone();
    instrDone = 1; step(); instrDone = 0;
  endtask

  task automatic doDi();
    diCmd = 1; step(); diCmd = 0;
  endtask

  task automatic doAck();
    irqAck = 1; step(); irqAck = 0;
  endtask

  task automatic skipTest(input logic [1:0] s, input int exp, input string req);
    skipReq = 1; skipSrc = s; step(); skipReq = 0;
    chk(req, skipHit, exp);
  endtask

  task automatic holdPin(input logic v, input int n);
    extPin = v; repeat (n) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [3:0] e, m, pend, rem;
    logic       r1;
    logic [2:0] r3;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rstN = 1;
    step();

    // R9 reset state
    chk("R9 irqReq", irqReq, 0);
    chk("R9 skipHit", skipHit, 0);
    chk("R9 ctrlA", ctrlA, 0);
    chk("R9 ctrlB", ctrlB, 0);
    chk("R9 edgeCfg", edgeCfg, 0);

    // R6 unused bits read back, selector 3 writes nothing
    wrReg(2'd0, 4'b0010);
    chk("R6 ctrlA unused bit", ctrlA, 4'b0010);
    wrReg(2'd1, 4'b1110);
    chk("R6 ctrlB unused bits", ctrlB, 4'b1110);
    wrReg(2'd3, 4'b1111);
    chk("R6 sel3 ctrlA", ctrlA, 4'b0010);
    chk("R6 sel3 edge", edgeCfg, 0);

    // R2 flag latches while masked, global disabled
    pulseTmr(3'b010);
    chk("R2 masked no req", irqReq, 0);
    // R8 enabled source: skip reports 0 and keeps flag
    wrReg(2'd0, 4'b1000);
    skipTest(2'd2, 0, "R8 enabled skip");
    wrReg(2'd0, 4'b0000);
    skipTest(2'd2, 1, "R8 masked skip hit");
    skipTest(2'd2, 0, "R8 flag consumed");

    // R10 set wins over same-cycle skip clear
    tmrUnderflow = 3'b001; skipReq = 1; skipSrc = 2'd1; step();
    tmrUnderflow = 0; skipReq = 0;
    chk("R10 old value reported", skipHit, 0);
    skipTest(2'd1, 1, "R10 flag survives");

    // R5 delayed enable and DI cancel
    wrReg(2'd1, 4'b0001);
    pulseTmr(3'b100);
    doEi();
    chk("R5 no req before next instr", irqReq, 0);
    doDi();
    doDone();
    chk("R5 DI cancels pending enable", irqReq, 0);
    doEi();
    step();
    chk("R5 still waiting", irqReq, 0);
    doDone();
    chk("R5 enabled after instr", irqReq, 1);
    chk("R4 timer3 vector", vecAddr, 'h88);
    chk("R4 timer3 src", irqSrc, 3);
    doAck();
    chk("R3 ack drops req", irqReq, 0);
    wrReg(2'd1, 4'b0000);

    // R3 only serviced flag cleared; R4 priority t1 over t2
    wrReg(2'd0, 4'b1100);
    pulseTmr(3'b011);
    doEi(); doDone();
    chk("R1 req with pending", irqReq, 1);
    chk("R4 timer1 vector", vecAddr, 'h84);
    doAck();
    chk("R3 gie cleared", irqReq, 0);
    doEi(); doDone();
    chk("R3 timer2 kept", irqReq, 1);
    chk("R4 timer2 vector", vecAddr, 'h86);
    doAck();
    doDi();
    wrReg(2'd0, 4'b0000);

    // R7 edge filtering, falling selected
    holdPin(0, 2); holdPin(1, 10);
    skipTest(2'd0, 0, "R7 glitch ignored");
    holdPin(0, 10);
    skipTest(2'd0, 1, "R7 falling edge");
    holdPin(1, 10);
    skipTest(2'd0, 0, "R7 rising ignored");
    wrReg(2'd2, 4'b0100);
    chk("R6 edge cfg", edgeCfg, 4'b0100);
    holdPin(0, 10);
    skipTest(2'd0, 0, "R7 falling ignored");
    holdPin(1, 10);
    skipTest(2'd0, 1, "R7 rising edge");
    // R4 external beats timers
    pulseTmr(3'b111);
    holdPin(0, 10); holdPin(1, 10);
    wrReg(2'd0, 4'b1101); wrReg(2'd1, 4'b0001);
    doEi(); doDone();
    chk("R4 ext vector", vecAddr, 'h80);
    chk("R4 ext src", irqSrc, 0);
    doAck(); doDi();
    wrReg(2'd0, 0); wrReg(2'd1, 0);
    skipTest(2'd0, 0, "R3 ext serviced");
    for (int s = 1; s < 4; s++) skipTest(s[1:0], 1, "R3 timers kept");

    // random phase
    for (int it = 0; it < 40; it++) begin
      e  = 4'($urandom % 16);
      m  = 4'(($urandom % 8) << 1);
      r1 = 1'($urandom % 2);
      r3 = 3'($urandom % 8);
      wrReg(2'd0, {e[2], e[1], r1, e[0]});
      chk("R6 random ctrlA", ctrlA, {e[2], e[1], r1, e[0]});
      wrReg(2'd1, {r3, e[3]});
      chk("R6 random ctrlB", ctrlB, {r3, e[3]});
      pulseTmr(m[3:1]);
      chk("R2 random no gie", irqReq, 0);
      doEi(); doDone();
      pend = m & e;
      chk("R1 random req", irqReq, int'(|pend));
      rem = m;
      if (|pend) begin
        chk("R4 random vector", vecAddr, expVec(pend));
        rem[expSrc(pend)] = 1'b0;
        doAck();
        chk("R3 random ack", irqReq, 0);
      end
      doDi();
      wrReg(2'd0, 0); wrReg(2'd1, 0);
      for (int s = 0; s < 4; s++) skipTest(s[1:0], int'(rem[s]), "R8 random skip");
    end

    report();
  end
endmodule